// File: doc/BRIEF.md
# Local Bus Cycle Timeout Monitor

This block guards each local bus transaction against a target that never answers. When a transaction begins, a down-counter is armed with a limit equal to the programmed count times the programmed prescale factor. Every acknowledged data beat re-arms the counter with the full limit. When the data tenure ends and nothing else is waiting, the monitor goes quiet. If the counter runs out first, the block raises a one-cycle timeout pulse. The bus engine uses this pulse to end the stuck access.

A sticky status flag records each timeout and is cleared by a write-one-to-clear strobe. A disable bit keeps the timeout from touching the flag, but the counter still runs and the pulse still ends the access. Limits shorter than 40 bus cycles are unsafe, so any smaller product is raised to 40 and a sticky warning bit is set.

Top module: `lbus_cycle_watchdog`

## Requirements
- R1: With no other event after a start seen while idle, `timeout_pulse_o` goes high exactly L cycles after the clock edge that sampled `xact_start_i`, where L = max(`cfg_count_i` × `cfg_prescale_i`, 40).
- R2: A product below 40 is raised to 40 cycles. When such a limit is loaded, `cfg_warn_o` is set, and it stays set until reset.
- R3: An acknowledged beat (`beat_ack_i`) during a transaction re-arms the counter with the full L, so the pulse comes L cycles after the acknowledge edge.
- R4: `tenure_done_i` without `xact_start_i` or `xact_pending_i` in the same cycle returns the monitor to idle, and no pulse follows.
- R5: `tenure_done_i` together with `xact_start_i` or `xact_pending_i` re-arms the counter directly with L, without passing through idle.
- R6: The timeout pulse lasts exactly one cycle. After it the monitor is idle and gives no further pulse until a new start.
- R7: With `cfg_flag_disable_i` low, a timeout sets `timeout_flag_o` in the same cycle as the pulse, and the flag stays set until `flag_clear_i`.
- R8: With `cfg_flag_disable_i` high, a timeout still produces the pulse but leaves `timeout_flag_o` unchanged.
- R9: `flag_clear_i` clears the flag on the next edge. If a timeout sets the flag on that same edge, the flag ends up set.
- R10: During and after reset, `timeout_pulse_o`, `timeout_flag_o` and `cfg_warn_o` are low and the monitor is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xact_start_i | input | 1 | A transaction begins |
| beat_ack_i | input | 1 | A data beat is acknowledged |
| tenure_done_i | input | 1 | The data tenure completes |
| xact_pending_i | input | 1 | Another transaction is waiting |
| cfg_count_i | input | CNT_W (8) | Timeout count |
| cfg_prescale_i | input | PS_W (4) | Prescale factor |
| cfg_flag_disable_i | input | 1 | Keeps timeouts from setting the flag |
| flag_clear_i | input | 1 | Write-one-to-clear for the flag |
| timeout_pulse_o | output | 1 | One-cycle access termination |
| timeout_flag_o | output | 1 | Sticky timeout status |
| cfg_warn_o | output | 1 | Sticky notice that a limit was clamped |

## Verification
The bench cannot read the counter, so a wrong count shows up only as a timeout pulse that arrives early or late. That error appears a full limit (at least 40 cycles) after the last start, acknowledge or re-arm. A missed return to idle shows up as a pulse where none should come, and only after one whole limit has passed. A wrong flag or warning state shows at the port on the same edge as the pulse or the load. For that reason each measurement counts cycles exactly rather than checking that a pulse arrived within some window.

// File: rtl/lbwd_pkg.sv
package lbwd_pkg;
  typedef enum logic {WD_IDLE, WD_RUN} wd_state_e;

  // Raise a product to the safe floor.
  function automatic logic [31:0] clamp_limit(input logic [31:0] prod,
                                              input logic [31:0] floor_v);
    return (prod < floor_v) ? floor_v : prod;
  endfunction
endpackage

// File: rtl/lbwd_limit_calc.sv
module lbwd_limit_calc #(
  parameter int CNT_W   = 8,
  parameter int PS_W    = 4,
  parameter int MIN_CYC = 40,
  parameter int LIM_W   = 12
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [PS_W-1:0]  prescale_i,
  output logic [LIM_W-1:0] limit_o,
  output logic             clamped_o
);
  import lbwd_pkg::*;

  logic [31:0] prod;
  logic [31:0] lim32;

  always_comb begin
    prod      = 32'(count_i) * 32'(prescale_i);
    lim32     = clamp_limit(prod, 32'(MIN_CYC));
    clamped_o = (prod < 32'(MIN_CYC));
    limit_o   = lim32[LIM_W-1:0];
  end
endmodule

// File: rtl/lbwd_countdown.sv
module lbwd_countdown #(
  parameter int LIM_W   = 12,
  parameter int MIN_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic             tenure_i,
  input  logic             pending_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             load_o,
  output logic             expire_evt_o,
  output logic             expire_o,
  output logic             busy_o
);
  import lbwd_pkg::*;

  wd_state_e        state_q;
  logic [LIM_W-1:0] cnt_q;
  logic             go_idle;

  assign busy_o = (state_q == WD_RUN);

  always_comb begin
    go_idle      = busy_o & tenure_i & ~pending_i & ~start_i;
    load_o       = start_i | (busy_o & ~go_idle & (ack_i | tenure_i));
    expire_evt_o = busy_o & ~load_o & ~go_idle & (cnt_q == LIM_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WD_IDLE;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= expire_evt_o;
      if (load_o) begin
        state_q <= WD_RUN;
        cnt_q   <= limit_i;
      end else if (go_idle || expire_evt_o) begin
        state_q <= WD_IDLE;
        cnt_q   <= '0;
      end else if (busy_o) begin
        cnt_q <= cnt_q - LIM_W'(1);
      end
    end
  end

  // R2: every armed count is at least the floor
  a_r2_armed_floor: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (busy_o && cnt_q >= LIM_W'(MIN_CYC)));
  // R4: tenure end with nothing waiting leads to idle
  a_r4_tenure_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tenure_i && !pending_i && !start_i) |=> !busy_o);
  // R6: single-cycle pulse, idle afterwards
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
  a_r6_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/lbwd_status.sv
module lbwd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt_i,
  input  logic disable_i,
  input  logic clear_i,
  input  logic warn_evt_i,
  output logic flag_o,
  output logic warn_o
);
  logic set_flag;
  assign set_flag = expire_evt_i & ~disable_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      warn_o <= 1'b0;
    end else begin
      if (set_flag)     flag_o <= 1'b1;
      else if (clear_i) flag_o <= 1'b0;
      if (warn_evt_i)   warn_o <= 1'b1;
    end
  end

  // R7: flag holds until cleared
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clear_i) |=> flag_o);
  // R8: disabled timeouts leave the flag alone
  a_r8_disable_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt_i && disable_i && !clear_i) |=> (flag_o == $past(flag_o)));
  // R9: set beats clear on the same edge
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt_i && !disable_i && clear_i) |=> flag_o);
  // R2: warning is sticky
  a_r2_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    warn_o |=> warn_o);
endmodule

// File: rtl/lbus_cycle_watchdog.sv
module lbus_cycle_watchdog #(
  parameter int CNT_W   = 8,
  parameter int PS_W    = 4,
  parameter int MIN_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xact_start_i,
  input  logic             beat_ack_i,
  input  logic             tenure_done_i,
  input  logic             xact_pending_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic [PS_W-1:0]  cfg_prescale_i,
  input  logic             cfg_flag_disable_i,
  input  logic             flag_clear_i,
  output logic             timeout_pulse_o,
  output logic             timeout_flag_o,
  output logic             cfg_warn_o
);
  localparam int PROD_W = CNT_W + PS_W;
  localparam int LIM_W  = (PROD_W > $clog2(MIN_CYC + 1)) ? PROD_W : $clog2(MIN_CYC + 1);

  logic [LIM_W-1:0] limit;
  logic             clamped;
  logic             load_evt;
  logic             expire_evt;
  logic             busy;

  lbwd_limit_calc #(.CNT_W(CNT_W), .PS_W(PS_W), .MIN_CYC(MIN_CYC), .LIM_W(LIM_W)) u_limit (
    .count_i   (cfg_count_i),
    .prescale_i(cfg_prescale_i),
    .limit_o   (limit),
    .clamped_o (clamped)
  );

  lbwd_countdown #(.LIM_W(LIM_W), .MIN_CYC(MIN_CYC)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (xact_start_i),
    .ack_i       (beat_ack_i),
    .tenure_i    (tenure_done_i),
    .pending_i   (xact_pending_i),
    .limit_i     (limit),
    .load_o      (load_evt),
    .expire_evt_o(expire_evt),
    .expire_o    (timeout_pulse_o),
    .busy_o      (busy)
  );

  lbwd_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire_evt_i(expire_evt),
    .disable_i   (cfg_flag_disable_i),
    .clear_i     (flag_clear_i),
    .warn_evt_i  (load_evt & clamped),
    .flag_o      (timeout_flag_o),
    .warn_o      (cfg_warn_o)
  );

  // R1: a pulse only ever follows a running countdown
  a_r1_pulse_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse_o |-> $past(busy));
  // R7: an enabled timeout shows on the flag with the pulse
  a_r7_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_pulse_o && !$past(cfg_flag_disable_i)) |-> timeout_flag_o);
endmodule

// File: tb/lbus_cycle_watchdog_tb_top.sv
`timescale 1ns/1ps
module lbus_cycle_watchdog_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, ack = 0, tend = 0, pend = 0, dis = 0, clr = 0;
  logic [7:0] cnt = 8'd10;
  logic [3:0] ps = 4'd4;
  logic pulse, flag, warn;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  lbus_cycle_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .xact_start_i(start), .beat_ack_i(ack),
    .tenure_done_i(tend), .xact_pending_i(pend), .cfg_count_i(cnt),
    .cfg_prescale_i(ps), .cfg_flag_disable_i(dis), .flag_clear_i(clr),
    .timeout_pulse_o(pulse), .timeout_flag_o(flag), .cfg_warn_o(warn)
  );

  // count, prescale, expected limit, expected warn afterwards
  localparam int VEC [6][4] = '{
    '{10, 4, 40, 0}, '{3, 15, 45, 0}, '{50, 1, 50, 0},
    '{7, 9, 63, 0},  '{5, 5, 40, 1},  '{0, 3, 40, 1}};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // Drive one cycle of inputs, starting and ending at a falling edge.
  task automatic drive(input logic s, a, t, p, c);
    start = s; ack = a; tend = t; pend = p; clr = c;
    @(negedge clk);
    start = 0; ack = 0; tend = 0; pend = 0; clr = 0;
  endtask

  task automatic wait_pulse(input int lim, output int n);
    n = 0;
    while (!pulse && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    chk(pulse == 0 && flag == 0 && warn == 0, "R10 reset", {pulse, flag, warn}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pulse == 0 && flag == 0 && warn == 0, "R10 after reset", {pulse, flag, warn}, 0);

    foreach (VEC[i]) begin
      cnt = 8'(VEC[i][0]); ps = 4'(VEC[i][1]);
      drive(1, 0, 0, 0, 0);
      wait_pulse(300, n);
      chk(n == VEC[i][2], "R1 limit", n, VEC[i][2]);
      chk(flag == 1, "R7 flag set", flag, 1);
      chk(warn == VEC[i][3], "R2 warn", warn, VEC[i][3]);
      @(negedge clk);
      chk(pulse == 0, "R6 one cycle", pulse, 0);
      chk(flag == 1, "R7 flag holds", flag, 1);
      drive(0, 0, 0, 0, 1);
      chk(flag == 0, "R9 clear", flag, 0);
    end

    // R6: no second pulse without a new start
    wait_pulse(120, n);
    chk(n == 120, "R6 stays idle", n, 120);

    cnt = 8'd10; ps = 4'd5; // L = 50
    // R3: acknowledge re-arms
    drive(1, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    drive(0, 1, 0, 0, 0);
    wait_pulse(300, n);
    chk(n == 50, "R3 ack reload", n, 50);
    drive(0, 0, 0, 0, 1);

    // R4: tenure end without pending goes idle
    drive(1, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    drive(0, 0, 1, 0, 0);
    wait_pulse(150, n);
    chk(n == 150 && pulse == 0, "R4 idle no pulse", n, 150);

    // R5: tenure with new start, and with pending
    drive(1, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    drive(1, 0, 1, 0, 0);
    wait_pulse(300, n);
    chk(n == 50, "R5 tenure+start", n, 50);
    drive(1, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    drive(0, 0, 1, 1, 0);
    wait_pulse(300, n);
    chk(n == 50, "R5 tenure+pending", n, 50);
    chk(flag == 1, "R7 flag set", flag, 1);
    drive(0, 0, 0, 0, 1);

    // R8: disable keeps flag clear but still pulses
    dis = 1;
    drive(1, 0, 0, 0, 0);
    wait_pulse(300, n);
    chk(n == 50, "R8 pulse still", n, 50);
    chk(flag == 0, "R8 flag untouched", flag, 0);
    @(negedge clk);
    dis = 0;

    // R9: set wins over same-edge clear
    drive(1, 0, 0, 0, 0);
    repeat (49) @(negedge clk);
    drive(0, 0, 0, 0, 1);
    chk(pulse == 1, "R9 pulse timing", pulse, 1);
    chk(flag == 1, "R9 set wins", flag, 1);
    drive(0, 0, 0, 0, 1);
    chk(flag == 0, "R9 clear after", flag, 0);
    chk(warn == 1, "R2 warn sticky", warn, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule